// File: doc/BRIEF.md
# Digit-Serial Carry-Save Montgomery Multiplier

This block computes the Montgomery product Z = X·Y·2^-K mod M for K-bit operands and an odd modulus M. It runs the radix-2 Montgomery recurrence with the running partial product kept as a redundant pair of vectors, a carry vector and a sum vector. No carry ever travels across the full word during the main loop. A chain of D radix-2 cells inside one clock retires D bits of X per cycle, so a product takes K/D cycles after it is accepted.

Each quotient bit is worked out one iteration early. It uses only the two lowest bits of the redundant state, the multiplicand, the modulus and the next bit of X. The wide adder rows therefore never wait on quotient logic.

A one-cycle start pulse loads X, Y and M. The block raises busy while it iterates and pulses done when the result is ready. The result leaves as the raw carry/sum pair, whose sum is congruent to the Montgomery product and lies below 2M. A separate final-conversion adder outside the block adds the pair and subtracts M once if needed.

Top module: `mmul_digit_serial`

## Requirements
- R1: For an odd M with its top bit set and X, Y below M, the value pc_o + ps_o at done is below 2M and is congruent to X·Y·2^-K modulo M.
- R2: done rises exactly K/D clock edges after the edge that samples an accepted start.
- R3: busy_o goes high on the edge that samples an accepted start and stays high until done rises. done is high for exactly one cycle, and busy_o is low in that cycle.
- R4: While the block is idle and start is low, pc_o and ps_o keep their values, whatever x_i, y_i and m_i do.
- R5: A start pulse seen while busy_o is high is ignored. The running product completes with its own operands, and no extra done pulse follows.
- R6: A start pulse in the same cycle as done is accepted, so products can run back to back with no idle cycle.
- R7: After reset, busy_o and done_o are low and pc_o and ps_o are zero.
- R8: Boundary operands give correct results: X = 0 gives a sum congruent to 0, and X = Y = M-1 and X with bit K-1 set are also handled. X bits at or above index K count as zero in the lookahead.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| start | input | 1 | One-cycle request to begin a product |
| x_i | input | K | Multiplier operand, consumed D bits per cycle from the LSB |
| y_i | input | K | Multiplicand operand |
| m_i | input | K | Odd modulus |
| busy_o | output | 1 | Product in progress |
| done_o | output | 1 | One-cycle pulse, result valid |
| pc_o | output | K+1 | Carry vector of the result |
| ps_o | output | K+1 | Sum vector of the result |

## Verification
Completion and acceptance of a new request can fall in the same cycle: done is high, busy_o has just dropped, and a fresh start arrives. The bench provokes this by holding the driver until it sees done and then raising start at once. It judges the cycle by two checks. The finishing product must still compare equal to its own reference. The new product must then finish K/D edges later with its own reference value. A second case drives start in the middle of a running product, and the scoreboard must see exactly one result, belonging to the first operands.

// File: rtl/mmul_pkg.sv
package mmul_pkg;

  // Control phases of the multiplier sequencer
  typedef enum logic {
    PH_IDLE = 1'b0,
    PH_RUN  = 1'b1
  } mmul_phase_e;

  // Majority of three vectors, the carry output of a full-adder row
  function automatic logic maj3(input logic a, input logic b, input logic c);
    return (a & b) | (a & c) | (b & c);
  endfunction

endpackage

// File: rtl/mmul_csa_cell.sv
// One radix-2 Montgomery step in redundant form with quotient lookahead.
module mmul_csa_cell #(
  parameter int K = 32
) (
  input  logic [K:0]   pc_i,
  input  logic [K:0]   ps_i,
  input  logic [K-1:0] y_i,
  input  logic [K-1:0] m_i,
  input  logic         xb_i,   // current multiplier bit
  input  logic         xn_i,   // next multiplier bit (lookahead)
  input  logic         q_i,    // quotient bit for this step
  output logic [K:0]   pc_o,
  output logic [K:0]   ps_o,
  output logic         q_o     // quotient bit for the following step
);
  import mmul_pkg::*;

  localparam int W = K + 1;

  logic [W-1:0] add_y;
  logic [W-1:0] add_m;
  logic [W-1:0] row1_s;
  logic [W-1:0] row1_c;
  logic [W:0]   r2_a;
  logic [W:0]   r2_b;
  logic [W:0]   r2_c;
  logic [W-1:0] row2_s_hi;
  logic [W-1:0] row2_c;
  logic [1:0]   low_sum;
  logic [1:0]   y_lo;
  logic [1:0]   m_lo;

  assign add_y = xb_i ? {1'b0, y_i} : '0;
  assign add_m = q_i  ? {1'b0, m_i} : '0;

  // First full-adder row: pc + ps + x*Y
  always_comb begin
    for (int b = 0; b < W; b++) begin
      row1_s[b] = pc_i[b] ^ ps_i[b] ^ add_y[b];
      row1_c[b] = maj3(pc_i[b], ps_i[b], add_y[b]);
    end
  end

  // Second row folds in q*M; carry of row one is weighted by two
  assign r2_a = {1'b0, row1_s};
  assign r2_b = {row1_c, 1'b0};
  assign r2_c = {1'b0, add_m};

  // The total is even, so the sum LSB is zero and is dropped by the shift.
  always_comb begin
    for (int b = 1; b <= W; b++) begin
      row2_s_hi[b-1] = r2_a[b] ^ r2_b[b] ^ r2_c[b];
    end
    for (int b = 0; b < W; b++) begin
      // carry weight 2^(b+1) becomes weight 2^b after the halving
      row2_c[b] = maj3(r2_a[b], r2_b[b], r2_c[b]);
    end
  end

  assign ps_o = row2_s_hi;
  assign pc_o = row2_c;

  // Lookahead: bit 1 of the low two bits of the pre-shift total is the
  // new LSB; combine it with x_{i+1}*y_0. The modulus LSB is taken as one.
  assign y_lo = xb_i ? y_i[1:0] : 2'b00;
  assign m_lo = q_i  ? {m_i[1], 1'b1} : 2'b00;
  assign low_sum = pc_i[1:0] + ps_i[1:0] + y_lo + m_lo;
  assign q_o = low_sum[1] ^ (xn_i & y_i[0]);

endmodule

// File: rtl/mmul_cell_chain.sv
// D cascaded cells: one clock retires D multiplier bits.
module mmul_cell_chain #(
  parameter int K = 32,
  parameter int D = 4
) (
  input  logic [K:0]   pc_i,
  input  logic [K:0]   ps_i,
  input  logic [K-1:0] y_i,
  input  logic [K-1:0] m_i,
  input  logic [D:0]   xwin_i,
  input  logic         q_i,
  output logic [K:0]   pc_o,
  output logic [K:0]   ps_o,
  output logic         q_o
);

  logic [K:0] pc_tap [D+1];
  logic [K:0] ps_tap [D+1];
  logic       q_tap  [D+1];

  assign pc_tap[0] = pc_i;
  assign ps_tap[0] = ps_i;
  assign q_tap[0]  = q_i;

  for (genvar j = 0; j < D; j++) begin : g_cell
    mmul_csa_cell #(.K(K)) u_cell (
      .pc_i (pc_tap[j]),
      .ps_i (ps_tap[j]),
      .y_i  (y_i),
      .m_i  (m_i),
      .xb_i (xwin_i[j]),
      .xn_i (xwin_i[j+1]),
      .q_i  (q_tap[j]),
      .pc_o (pc_tap[j+1]),
      .ps_o (ps_tap[j+1]),
      .q_o  (q_tap[j+1])
    );
  end

  assign pc_o = pc_tap[D];
  assign ps_o = ps_tap[D];
  assign q_o  = q_tap[D];

endmodule

// File: rtl/mmul_xwindow.sv
// Multiplier shift register: presents D+1 bits (D used, one lookahead).
module mmul_xwindow #(
  parameter int K = 32,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         load_i,
  input  logic         shift_i,
  input  logic [K-1:0] x_i,
  output logic [D:0]   win_o
);

  // One extra zero above bit K-1 so the last lookahead bit reads zero
  logic [K:0] xs_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      xs_q <= '0;
    end else if (load_i) begin
      xs_q <= {1'b0, x_i};
    end else if (shift_i) begin
      xs_q <= {{D{1'b0}}, xs_q[K:D]};
    end
  end

  assign win_o = xs_q[D:0];

endmodule

// File: rtl/mmul_seq.sv
// Sequencer: accepts a start when idle, counts K/D steps, pulses done.
module mmul_seq #(
  parameter int STEPS = 8
) (
  input  logic clk,
  input  logic rst,
  input  logic start_i,
  output logic load_o,
  output logic step_o,
  output logic busy_o,
  output logic done_o
);
  import mmul_pkg::*;

  localparam int CW = $clog2(STEPS + 1);
  localparam logic [CW-1:0] LAST = CW'(STEPS - 1);

  mmul_phase_e  phase_q;
  logic [CW-1:0] cnt_q;
  logic          done_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      phase_q <= PH_IDLE;
      cnt_q   <= '0;
      done_q  <= 1'b0;
    end else begin
      done_q <= 1'b0;
      case (phase_q)
        PH_RUN: begin
          cnt_q <= cnt_q + 1'b1;
          if (cnt_q == LAST) begin
            phase_q <= PH_IDLE;
            done_q  <= 1'b1;
          end
        end
        default: begin
          if (start_i) begin
            phase_q <= PH_RUN;
            cnt_q   <= '0;
          end
        end
      endcase
    end
  end

  assign busy_o = (phase_q == PH_RUN);
  assign done_o = done_q;
  assign load_o = start_i && (phase_q == PH_IDLE);
  assign step_o = (phase_q == PH_RUN);

endmodule

// File: rtl/mmul_digit_serial.sv
// Digit-serial carry-save Montgomery multiplier, Z = X*Y*2^-K mod M.
module mmul_digit_serial #(
  parameter int K = 32,
  parameter int D = 4
) (
  input  logic         clk,
  input  logic         rst,
  input  logic         start,
  input  logic [K-1:0] x_i,
  input  logic [K-1:0] y_i,
  input  logic [K-1:0] m_i,
  output logic         busy_o,
  output logic         done_o,
  output logic [K:0]   pc_o,
  output logic [K:0]   ps_o
);

  localparam int STEPS = K / D;

  initial begin
    if ((K % D) != 0 || D < 1 || K <= D) begin
      $error("mmul_digit_serial: K must be a multiple of D and larger than D");
    end
  end

  logic         load;
  logic         step;
  logic [D:0]   xwin;
  logic [K-1:0] y_r;
  logic [K-1:0] m_r;
  logic [K:0]   pc_r;
  logic [K:0]   ps_r;
  logic         q_r;
  logic [K:0]   pc_nx;
  logic [K:0]   ps_nx;
  logic         q_nx;

  mmul_seq #(.STEPS(STEPS)) u_seq (
    .clk     (clk),
    .rst     (rst),
    .start_i (start),
    .load_o  (load),
    .step_o  (step),
    .busy_o  (busy_o),
    .done_o  (done_o)
  );

  mmul_xwindow #(.K(K), .D(D)) u_xwin (
    .clk     (clk),
    .rst     (rst),
    .load_i  (load),
    .shift_i (step),
    .x_i     (x_i),
    .win_o   (xwin)
  );

  mmul_cell_chain #(.K(K), .D(D)) u_chain (
    .pc_i   (pc_r),
    .ps_i   (ps_r),
    .y_i    (y_r),
    .m_i    (m_r),
    .xwin_i (xwin),
    .q_i    (q_r),
    .pc_o   (pc_nx),
    .ps_o   (ps_nx),
    .q_o    (q_nx)
  );

  // Operand capture
  always_ff @(posedge clk) begin
    if (rst) begin
      y_r <= '0;
      m_r <= '0;
    end else if (load) begin
      y_r <= y_i;
      m_r <= m_i;
    end
  end

  // Redundant accumulator and quotient register
  always_ff @(posedge clk) begin
    if (rst) begin
      pc_r <= '0;
      ps_r <= '0;
      q_r  <= 1'b0;
    end else if (load) begin
      pc_r <= '0;
      ps_r <= '0;
      q_r  <= x_i[0] & y_i[0];
    end else if (step) begin
      pc_r <= pc_nx;
      ps_r <= ps_nx;
      q_r  <= q_nx;
    end
  end

  assign pc_o = pc_r;
  assign ps_o = ps_r;

endmodule

// File: rtl/mmul_digit_serial_chk.sv
// Protocol and range checks, bound to the top module.
module mmul_digit_serial_chk #(
  parameter int K = 32,
  parameter int D = 4
) (
  input logic         clk,
  input logic         rst,
  input logic         start,
  input logic         busy_o,
  input logic         done_o,
  input logic [K:0]   pc_o,
  input logic [K:0]   ps_o,
  input logic [K-1:0] mod_r
);

  localparam int STEPS = K / D;

  int unsigned run_edges;

  always_ff @(posedge clk) begin
    if (rst) begin
      run_edges <= 0;
    end else if (start && !busy_o) begin
      run_edges <= 0;
    end else if (busy_o) begin
      run_edges <= run_edges + 1;
    end
  end

  p_sum_below_2m_r1: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (({1'b0, pc_o} + {1'b0, ps_o}) < {1'b0, mod_r, 1'b0}));

  p_latency_r2: assert property (@(posedge clk) disable iff (rst)
    done_o |-> (run_edges == STEPS));

  p_done_single_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |=> !done_o);

  p_done_idle_r3: assert property (@(posedge clk) disable iff (rst)
    done_o |-> !busy_o);

  p_accept_r3: assert property (@(posedge clk) disable iff (rst)
    (start && !busy_o) |=> busy_o);

  p_hold_idle_r4: assert property (@(posedge clk) disable iff (rst)
    (!busy_o && !start) |=> ($stable(pc_o) && $stable(ps_o)));

  p_run_ends_in_done_r5: assert property (@(posedge clk) disable iff (rst)
    busy_o |=> (busy_o || done_o));

endmodule

bind mmul_digit_serial mmul_digit_serial_chk #(.K(K), .D(D)) u_chk (
  .clk    (clk),
  .rst    (rst),
  .start  (start),
  .busy_o (busy_o),
  .done_o (done_o),
  .pc_o   (pc_o),
  .ps_o   (ps_o),
  .mod_r  (m_r)
);

// File: tb/sim_mmul_digit_serial.sv
`timescale 1ns/1ps
module sim_mmul_digit_serial;

  localparam int K = 32;
  localparam int D = 4;
  localparam int STEPS = K / D;

  logic         clk = 1'b0;
  logic         rst = 1'b1;
  logic         start = 1'b0;
  logic [K-1:0] x_i = '0;
  logic [K-1:0] y_i = '0;
  logic [K-1:0] m_i = '0;
  logic         busy_o;
  logic         done_o;
  logic [K:0]   pc_o;
  logic [K:0]   ps_o;

  int checks = 0;
  int failures = 0;
  int unsigned cyc = 0;
  logic [K+1:0] last_sum = '0;

  typedef struct {
    logic [K-1:0] z;
    logic [K-1:0] m;
    int unsigned  due;
  } exp_t;

  exp_t sb[$];

  always #4 clk = ~clk;

  always @(posedge clk) cyc <= cyc + 1;

  mmul_digit_serial #(.K(K), .D(D)) u0 (
    .clk(clk), .rst(rst), .start(start),
    .x_i(x_i), .y_i(y_i), .m_i(m_i),
    .busy_o(busy_o), .done_o(done_o), .pc_o(pc_o), .ps_o(ps_o)
  );

  task automatic check(input bit ok, input string req, input string what,
                       input logic [127:0] act, input logic [127:0] exp);
    checks++;
    if (!ok) begin
      failures++;
      $display("FAIL %s %s actual=%0h expected=%0h", req, what, act, exp);
    end
  endtask

  // Reference: multiply, reduce, then halve K times modulo the odd M.
  function automatic logic [K-1:0] ref_mont(input logic [K-1:0] x,
                                            input logic [K-1:0] y,
                                            input logic [K-1:0] m);
    logic [127:0] t;
    t = (128'(x) * 128'(y)) % 128'(m);
    for (int i = 0; i < K; i++) begin
      if (t[0]) t = (t + 128'(m)) >> 1;
      else      t = t >> 1;
    end
    return t[K-1:0];
  endfunction

  // Drive a start in the current cycle (caller is at a negedge)
  task automatic issue(input logic [K-1:0] x, input logic [K-1:0] y,
                       input logic [K-1:0] m);
    exp_t e;
    bit   accepted;
    x_i = x; y_i = y; m_i = m; start = 1'b1;
    accepted = !busy_o;
    if (accepted) begin
      e.z = ref_mont(x, y, m);
      e.m = m;
      e.due = cyc + 1 + STEPS;
      sb.push_back(e);
    end
    @(negedge clk);
    start = 1'b0;
    if (accepted) check(busy_o == 1'b1, "R3", "busy after accept", 128'(busy_o), 128'(1));
  endtask

  task automatic go(input logic [K-1:0] x, input logic [K-1:0] y,
                    input logic [K-1:0] m);
    @(negedge clk);
    issue(x, y, m);
  endtask

  task automatic drain();
    while (sb.size() != 0 || busy_o) @(negedge clk);
    @(negedge clk);
  endtask

  // Monitor: pop and compare on every done
  logic done_prev = 1'b0;
  always @(negedge clk) begin
    if (!rst) begin
      if (done_o) begin
        logic [K+1:0] sum;
        logic [K+1:0] red;
        sum = {1'b0, pc_o} + {1'b0, ps_o};
        last_sum = sum;
        check(!busy_o, "R3", "busy low with done", 128'(busy_o), 128'(0));
        check(!done_prev, "R3", "done one cycle", 128'(done_prev), 128'(0));
        if (sb.size() == 0) begin
          check(1'b0, "R5", "unexpected done", 128'(sum), 128'(0));
        end else begin
          exp_t e;
          e = sb.pop_front();
          red = (sum >= {2'b0, e.m}) ? sum - {2'b0, e.m} : sum;
          check(sum < {1'b0, e.m, 1'b0}, "R1", "sum below 2M", 128'(sum), 128'({e.m, 1'b0}));
          check(red == {2'b0, e.z}, "R1", "reduced product", 128'(red), 128'(e.z));
          check(cyc == e.due, "R2", "done latency", 128'(cyc), 128'(e.due));
        end
      end
      done_prev <= done_o;
    end
  end

  initial begin
    repeat (150000) @(posedge clk);
    failures++;
    $display("FAIL R2 watchdog actual=timeout expected=completion");
    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    // R7: reset state
    check(busy_o == 1'b0, "R7", "busy in reset", 128'(busy_o), 128'(0));
    check(done_o == 1'b0, "R7", "done in reset", 128'(done_o), 128'(0));
    check(pc_o == '0, "R7", "pc in reset", 128'(pc_o), 128'(0));
    check(ps_o == '0, "R7", "ps in reset", 128'(ps_o), 128'(0));
    rst = 1'b0;
    @(negedge clk);

    // R8: boundary operands
    go(32'h0, 32'h1234_5677, 32'hFFFF_FFFB);
    drain();
    go(32'hFFFF_FFFA, 32'hFFFF_FFFA, 32'hFFFF_FFFB);
    drain();
    go(32'h8000_0001, 32'h7FFF_FFFF, 32'hC000_0001);
    drain();
    go(32'h1, 32'h1, 32'h8000_0001);
    drain();

    // R1: random operands
    for (int n = 0; n < 40; n++) begin
      logic [K-1:0] m, x, y;
      m = $urandom() | 32'h8000_0001;
      x = $urandom() % m;
      y = $urandom() % m;
      go(x, y, m);
      drain();
    end

    // R5: start while busy is ignored
    go(32'h1357_9BDF, 32'h2468_ACE0, 32'hE000_0007);
    repeat (3) @(negedge clk);
    issue(32'hFFFF_0000, 32'h0000_FFFF, 32'h9000_0001);
    drain();

    // R4: idle hold while inputs move
    for (int n = 0; n < 5; n++) begin
      x_i = $urandom(); y_i = $urandom(); m_i = $urandom() | 1;
      @(negedge clk);
      check(({1'b0, pc_o} + {1'b0, ps_o}) == last_sum, "R4", "idle hold",
            128'({1'b0, pc_o} + {1'b0, ps_o}), 128'(last_sum));
    end

    // R6: start in the done cycle, back to back
    go(32'h0BAD_F00D, 32'h1CE1_CE11, 32'hF123_4567);
    for (int n = 0; n < 3; n++) begin
      logic [K-1:0] m, x, y;
      m = $urandom() | 32'h8000_0001;
      x = $urandom() % m;
      y = $urandom() % m;
      do @(negedge clk); while (!done_o);
      check(!busy_o, "R6", "idle in done cycle", 128'(busy_o), 128'(0));
      issue(x, y, m);
    end
    drain();

    $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
    $finish;
  end

endmodule